// File: doc/BRIEF.md
# Serial Register-Access Port (Slave Side)

This block lets an external host read and write an on-chip register space over a three-wire serial link: an active-low select `csb`, a host-driven clock `sclk` and a bidirectional data pin. A second output pin can carry read data instead. All three pin inputs pass through synchronizers into the block clock `clk`. Every SCLK edge then becomes a single-cycle event, so the host clock must be several times slower than `clk`. The register file sits on the `clk` side.

Each frame opens with a 16-bit header sent most significant bit first. The header holds a direction flag, a two-bit length code and a 13-bit start address. Whole data bytes follow, and the address steps after each byte. A short frame of one to three bytes may be suspended by raising `csb` between bytes and resumed by lowering it again. Length code 3 keeps the frame open until `csb` rises.

The register-side interface carries no back-pressure. A serial link cannot be stalled, so `reg_we` is a one-cycle strobe that is always accepted. `reg_rdata` must be valid in the same cycle as `reg_re` for the address on `reg_addr`.

Top module: `serial_regport`

## Requirements
- R1: After reset `reg_we`, `reg_re`, `sdio_oe` and `sdo_oe` are all low.
- R2: The header is sampled on rising SCLK, MSB first. Header bit 15 is the direction (1 = read, 0 = write). Bits 14:13 are the length code. Bits 12:0 are the start address.
- R3: In a write frame, each completed data byte, sampled MSB first, produces exactly one `reg_we` pulse. The pulse carries the byte and its address. Codes 0, 1 and 2 transfer 1, 2 and 3 bytes.
- R4: In a read frame with `cfg_sdo_en`=0, each byte leaves on `sdio_o` MSB first, with `sdio_oe` high. Bits change after falling SCLK. The first bit is valid before the first rising edge after the header.
- R5: With `cfg_sdo_en`=1, read data leaves on `sdo_o` with `sdo_oe` high, and `sdio_oe` stays low.
- R6: Length code 3 streams bytes, in either direction, until `csb` rises.
- R7: With `cfg_addr_dec`=0 the address increments after each byte, and 0x0FF is followed by 0x000.
- R8: With `cfg_addr_dec`=1 the address decrements after each byte, and 0x000 is followed by 0x0FF.
- R9: A rise of `csb` on a byte boundary, before three data bytes have completed, suspends the frame. The next fall resumes it at the next address, without a new header.
- R10: A rise of `csb` mid-byte, or during the header, ends the frame. The partial byte is dropped, completed bytes stay written, and the next frame begins with a header.
- R11: A streaming frame past its third byte ends when `csb` rises. The next fall begins a new header.
- R12: With `csb` held low, a frame ends when its byte count is met and the next rising SCLK begins a new header. This also applies to the first frame after reset.
- R13: A read fetches each byte with one `reg_re` pulse at the current address before the byte's first bit is shifted out. Write frames raise no `reg_re`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csb | input | 1 | Active-low frame select from host |
| sclk | input | 1 | Serial clock from host |
| sdio_i | input | 1 | Data pin, input side |
| sdio_o | output | 1 | Data pin, output side |
| sdio_oe | output | 1 | Data pin output enable |
| sdo_o | output | 1 | Separate read-data output |
| sdo_oe | output | 1 | Separate read-data output enable |
| cfg_sdo_en | input | 1 | Route read data to `sdo_o` |
| cfg_addr_dec | input | 1 | Decrement address after each byte |
| reg_addr | output | 13 | Register address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | Register write strobe |
| reg_re | output | 1 | Register read fetch strobe |
| reg_rdata | input | 8 | Register read data |

## Verification
A write strobe appears about three `clk` cycles after the eighth rising SCLK of its byte. This delay comes from two synchronizer stages plus an edge register. The scoreboard monitor therefore pops the expected address and data on the falling `clk` edge of whichever cycle `reg_we` is seen, and does not wait for a fixed slot. Read bits settle about three cycles after each falling SCLK. The bench samples the data pin and its enable eight cycles later, just before raising SCLK. Strobe counts and output enables are read only after each frame has settled.

// File: rtl/serial_regport_pkg.sv
package serial_regport_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_INSTR, ST_DATA, ST_PAUSE} port_state_e;
  localparam logic [1:0] LEN_STREAM  = 2'b11;
  localparam int         STALL_BYTES = 3;
endpackage

// File: rtl/serial_regport_sync.sv
module serial_regport_sync #(
  parameter int             W      = 1,
  parameter int             STAGES = 2,
  parameter logic [W-1:0]   INIT   = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[g] <= INIT;
        else        pipe[g] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) pipe[g] <= INIT;
        else        pipe[g] <= pipe[g-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/serial_regport_rdshift.sv
module serial_regport_rdshift #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [DATA_W-1:0] din,
  output logic              bit_o
);
  logic [DATA_W-1:0] sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     sh <= '0;
    else if (load)  sh <= din;
    else if (shift) sh <= {sh[DATA_W-2:0], 1'b0};

  assign bit_o = sh[DATA_W-1];
endmodule

// File: rtl/serial_regport_ctrl.sv
module serial_regport_ctrl
  import serial_regport_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int DATA_W  = 8,
  parameter int WRAP_HI = 255
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              csb_s,
  input  logic              din_s,
  input  logic              cfg_addr_dec,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              we_o,
  output logic              fetch_o,
  output logic              shift_o,
  output logic              rd_active_o
);
  localparam int INSTR_W = ADDR_W + 3;
  localparam int ICNT_W  = $clog2(INSTR_W);
  localparam int BCNT_W  = $clog2(DATA_W);
  localparam logic [ADDR_W-1:0] WRAP_A = ADDR_W'(WRAP_HI);

  port_state_e         state;
  logic                sclk_d, csb_d;
  logic [ICNT_W-1:0]   icnt;
  logic [INSTR_W-2:0]  ish;
  logic [BCNT_W-1:0]   bpos;
  logic [1:0]          bytes_done;
  logic                is_rd;
  logic [1:0]          wlen;
  logic [DATA_W-2:0]   bsh;
  logic                adv;

  logic sclk_rise, sclk_fall, csb_rise, csb_fall;
  logic [INSTR_W-1:0] instr_word;
  logic [DATA_W-1:0]  byte_word;
  logic last_byte, pause_ok, byte_end;

  function automatic logic [ADDR_W-1:0] step_addr(input logic [ADDR_W-1:0] a, input logic dec);
    if (dec) return (a == '0) ? WRAP_A : a - ADDR_W'(1);
    else     return (a == WRAP_A) ? '0 : a + ADDR_W'(1);
  endfunction

  assign sclk_rise  = sclk_s & ~sclk_d;
  assign sclk_fall  = ~sclk_s & sclk_d;
  assign csb_rise   = csb_s & ~csb_d;
  assign csb_fall   = ~csb_s & csb_d;
  assign instr_word = {ish, din_s};
  assign byte_word  = {bsh, din_s};
  assign byte_end   = (bpos == BCNT_W'(DATA_W-1));
  assign last_byte  = (wlen != LEN_STREAM) && (bytes_done == wlen);
  assign pause_ok   = (bpos == '0) && (bytes_done < 2'(STALL_BYTES));

  assign rd_active_o = (state == ST_DATA) && is_rd;
  assign fetch_o     = rd_active_o && sclk_fall && (bpos == '0);
  assign shift_o     = rd_active_o && sclk_fall && (bpos != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; sclk_d <= 1'b0; csb_d <= 1'b1;
      icnt <= '0; ish <= '0; bpos <= '0; bytes_done <= '0;
      is_rd <= 1'b0; wlen <= '0; bsh <= '0; adv <= 1'b0;
      addr_o <= '0; wdata_o <= '0; we_o <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      csb_d  <= csb_s;
      we_o   <= 1'b0;
      if (adv) begin
        addr_o <= step_addr(addr_o, cfg_addr_dec);
        adv    <= 1'b0;
      end
      case (state)
        ST_IDLE: if (!csb_s && sclk_rise) begin
          ish   <= {{(INSTR_W-2){1'b0}}, din_s};
          icnt  <= ICNT_W'(1);
          state <= ST_INSTR;
        end
        ST_INSTR: begin
          if (csb_rise) state <= ST_IDLE;
          else if (sclk_rise) begin
            ish  <= instr_word[INSTR_W-2:0];
            icnt <= icnt + ICNT_W'(1);
            if (icnt == ICNT_W'(INSTR_W-1)) begin
              is_rd      <= instr_word[INSTR_W-1];
              wlen       <= instr_word[INSTR_W-2 -: 2];
              addr_o     <= instr_word[ADDR_W-1:0];
              bpos       <= '0;
              bytes_done <= '0;
              state      <= ST_DATA;
            end
          end
        end
        ST_DATA: begin
          if (csb_rise) state <= pause_ok ? ST_PAUSE : ST_IDLE;
          else if (sclk_rise) begin
            bsh  <= byte_word[DATA_W-2:0];
            bpos <= byte_end ? '0 : bpos + BCNT_W'(1);
            if (byte_end) begin
              we_o    <= !is_rd;
              wdata_o <= byte_word;
              adv     <= 1'b1;
              if (bytes_done != 2'b11) bytes_done <= bytes_done + 2'd1;
              if (last_byte) state <= ST_IDLE;
            end
          end
        end
        ST_PAUSE: if (csb_fall) state <= ST_DATA;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_regport.sv
module serial_regport
  import serial_regport_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int DATA_W      = 8,
  parameter int WRAP_HI     = 255,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csb,
  input  logic              sclk,
  input  logic              sdio_i,
  output logic              sdio_o,
  output logic              sdio_oe,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic              cfg_sdo_en,
  input  logic              cfg_addr_dec,
  output logic [ADDR_W-1:0] reg_addr,
  output logic [DATA_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_re,
  input  logic [DATA_W-1:0] reg_rdata
);
  logic csb_s, sclk_s, din_s;
  logic fetch, shift, rd_active, rd_bit;

  serial_regport_sync #(.W(3), .STAGES(SYNC_STAGES), .INIT(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({csb, sclk, sdio_i}),
    .q({csb_s, sclk_s, din_s})
  );

  serial_regport_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WRAP_HI(WRAP_HI)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .csb_s(csb_s), .din_s(din_s),
    .cfg_addr_dec(cfg_addr_dec),
    .addr_o(reg_addr), .wdata_o(reg_wdata), .we_o(reg_we),
    .fetch_o(fetch), .shift_o(shift), .rd_active_o(rd_active)
  );

  serial_regport_rdshift #(.DATA_W(DATA_W)) u_rdsh (
    .clk(clk), .rst_n(rst_n),
    .load(fetch), .shift(shift), .din(reg_rdata), .bit_o(rd_bit)
  );

  assign reg_re  = fetch;
  assign sdio_o  = rd_bit;
  assign sdo_o   = rd_bit;
  assign sdio_oe = rd_active & ~csb & ~cfg_sdo_en;
  assign sdo_oe  = rd_active & ~csb & cfg_sdo_en;
endmodule

// File: rtl/serial_regport_chk.sv
module serial_regport_chk #(
  parameter int ADDR_W  = 13,
  parameter int WRAP_HI = 255
) (
  input logic              clk,
  input logic              rst_n,
  input logic              csb,
  input logic              cfg_addr_dec,
  input logic              sdio_oe,
  input logic              sdo_oe,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic              reg_re
);
  localparam logic [ADDR_W-1:0] WRAP_A = ADDR_W'(WRAP_HI);

  p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  p_we_quiet_pins_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (!sdio_oe && !sdo_oe));

  p_inc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !cfg_addr_dec && reg_addr != WRAP_A) |=> ((reg_addr - $past(reg_addr)) == ADDR_W'(1)));

  p_inc_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !cfg_addr_dec && reg_addr == WRAP_A) |=> (reg_addr == '0));

  p_dec_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && cfg_addr_dec && reg_addr != '0) |=> (($past(reg_addr) - reg_addr) == ADDR_W'(1)));

  p_dec_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && cfg_addr_dec && reg_addr == '0) |=> (reg_addr == WRAP_A));

  p_fetch_in_frame_r13: assert property (@(posedge clk) disable iff (!rst_n)
    reg_re |-> (!csb && !reg_we));
endmodule

bind serial_regport serial_regport_chk #(.ADDR_W(ADDR_W), .WRAP_HI(WRAP_HI)) chk_i (
  .clk(clk), .rst_n(rst_n), .csb(csb), .cfg_addr_dec(cfg_addr_dec),
  .sdio_oe(sdio_oe), .sdo_oe(sdo_oe), .reg_addr(reg_addr),
  .reg_we(reg_we), .reg_re(reg_re)
);

// File: tb/serial_regport_tb_top.sv
module serial_regport_tb_top;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0, csb = 1'b1, sclk = 1'b0, sdio_drv = 1'b0;
  logic cfg_sdo_en = 1'b0, cfg_addr_dec = 1'b0;
  logic sdio_o, sdio_oe, sdo_o, sdo_oe, reg_we, reg_re;
  logic [12:0] reg_addr;
  logic [7:0]  reg_wdata, reg_rdata;

  logic [7:0] bmem    [0:511] = '{default: 8'h00};
  logic [7:0] ref_mem [0:511] = '{default: 8'h00};
  logic [20:0] wr_q [$];
  int vec = 0, errs = 0, we_cnt = 0, re_cnt = 0;

  serial_regport dut_i (
    .clk(clk), .rst_n(rst_n), .csb(csb), .sclk(sclk), .sdio_i(sdio_drv),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .cfg_sdo_en(cfg_sdo_en), .cfg_addr_dec(cfg_addr_dec),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_re(reg_re), .reg_rdata(reg_rdata)
  );

  assign reg_rdata = bmem[reg_addr[8:0]];
  always @(posedge clk) if (reg_we) bmem[reg_addr[8:0]] <= reg_wdata;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    vec++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) if (rst_n) begin
    if (reg_re) re_cnt++;
    if (reg_we) begin
      we_cnt++;
      if (wr_q.size() == 0) chk(1'b0, "R3", "unexpected write strobe", {reg_addr, reg_wdata}, 0);
      else begin
        logic [20:0] e;
        e = wr_q.pop_front();
        chk({reg_addr, reg_wdata} == e, "R3", "write addr/data", {reg_addr, reg_wdata}, e);
      end
    end
  end

  function automatic logic [12:0] nxt(input logic [12:0] a);
    if (cfg_addr_dec) return (a == 13'h0)  ? 13'h0FF : a - 13'd1;
    else              return (a == 13'h0FF) ? 13'h000 : a + 13'd1;
  endfunction

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic send_bit(input bit b);
    sdio_drv = b; tick(HALF); sclk = 1'b1; tick(HALF); sclk = 1'b0;
  endtask

  task automatic recv_bit(output bit b, output bit oe_ok);
    tick(HALF);
    b = cfg_sdo_en ? sdo_o : sdio_o;
    oe_ok = cfg_sdo_en ? (sdo_oe && !sdio_oe) : (sdio_oe && !sdo_oe);
    sclk = 1'b1; tick(HALF); sclk = 1'b0;
  endtask

  task automatic fbegin; csb = 1'b0; tick(4); endtask
  task automatic fend;   tick(HALF); csb = 1'b1; tick(8); endtask

  task automatic send_instr(input bit rd, input bit [1:0] len, input logic [12:0] a);
    logic [15:0] w;
    w = {rd, len, a};
    for (int i = 15; i >= 0; i--) send_bit(w[i]);
  endtask

  task automatic send_byte(input logic [12:0] a, input logic [7:0] d);
    ref_mem[a[8:0]] = d;
    wr_q.push_back({a, d});
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
  endtask

  task automatic recv_byte(input logic [12:0] a, input string req);
    logic [7:0] got;
    bit b, ok, all_ok;
    all_ok = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      recv_bit(b, ok);
      got[i] = b;
      all_ok = all_ok & ok;
    end
    chk(got == ref_mem[a[8:0]], req, "read byte", got, ref_mem[a[8:0]]);
    chk(all_ok, req, "output enable select", all_ok, 1);
  endtask

  task automatic wr_bytes(inout logic [12:0] a, input int n, input int seed);
    for (int i = 0; i < n; i++) begin
      send_byte(a, 8'(seed + i * 37));
      a = nxt(a);
    end
  endtask

  task automatic rd_bytes(inout logic [12:0] a, input int n, input string req);
    for (int i = 0; i < n; i++) begin
      recv_byte(a, req);
      a = nxt(a);
    end
  endtask

  task automatic drained(input string req);
    tick(4);
    chk(wr_q.size() == 0, req, "pending expected writes", wr_q.size(), 0);
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vec, errs);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [12:0] a;
    int w0, r0;
    tick(5); rst_n = 1'b1; tick(5);

    // R1 reset state
    chk(!reg_we && !reg_re, "R1", "strobes after reset", {reg_we, reg_re}, 0);
    chk(!sdio_oe && !sdo_oe, "R1", "enables after reset", {sdio_oe, sdo_oe}, 0);

    // R2 R3 single-byte write, code 0
    w0 = we_cnt; r0 = re_cnt;
    fbegin(); send_instr(1'b0, 2'd0, 13'h010); send_byte(13'h010, 8'hA5); fend();
    drained("R2");
    chk(we_cnt - w0 == 1, "R3", "strobes code0", we_cnt - w0, 1);
    chk(re_cnt == r0, "R13", "no fetch in write", re_cnt - r0, 0);

    // R3 three-byte write, code 2
    w0 = we_cnt; a = 13'h020;
    fbegin(); send_instr(1'b0, 2'd2, a); wr_bytes(a, 3, 8'h11); fend();
    drained("R3");
    chk(we_cnt - w0 == 3, "R3", "strobes code2", we_cnt - w0, 3);

    // R4 R13 read on SDIO, code 1
    r0 = re_cnt; a = 13'h020;
    fbegin(); send_instr(1'b1, 2'd1, a); rd_bytes(a, 2, "R4"); fend();
    chk(re_cnt - r0 == 2, "R13", "fetch count code1", re_cnt - r0, 2);
    chk(!sdio_oe, "R4", "sdio released after read", sdio_oe, 0);

    // R5 read on SDO, code 2
    cfg_sdo_en = 1'b1; r0 = re_cnt; a = 13'h020;
    fbegin(); send_instr(1'b1, 2'd2, a); rd_bytes(a, 3, "R5"); fend();
    chk(re_cnt - r0 == 3, "R13", "fetch count code2", re_cnt - r0, 3);
    cfg_sdo_en = 1'b0;

    // R7 increment wrap
    a = 13'h0FE;
    fbegin(); send_instr(1'b0, 2'd2, a); wr_bytes(a, 3, 8'h5C); fend();
    drained("R7");
    a = 13'h0FE;
    fbegin(); send_instr(1'b1, 2'd2, a); rd_bytes(a, 3, "R7"); fend();

    // R8 decrement wrap
    cfg_addr_dec = 1'b1; a = 13'h001;
    fbegin(); send_instr(1'b0, 2'd2, a); wr_bytes(a, 3, 8'hC3); fend();
    drained("R8");
    a = 13'h001;
    fbegin(); send_instr(1'b1, 2'd2, a); rd_bytes(a, 3, "R8"); fend();
    cfg_addr_dec = 1'b0;

    // R6 streaming write and read of six bytes
    a = 13'h040;
    fbegin(); send_instr(1'b0, 2'd3, a); wr_bytes(a, 6, 8'h29); fend();
    drained("R6");
    a = 13'h040;
    fbegin(); send_instr(1'b1, 2'd3, a); rd_bytes(a, 6, "R6"); fend();

    // R11 streaming past third byte, then new header
    a = 13'h050;
    fbegin(); send_instr(1'b0, 2'd3, a); wr_bytes(a, 4, 8'h91); fend();
    drained("R11");
    chk(!sdio_oe && !sdo_oe, "R11", "idle after stream", {sdio_oe, sdo_oe}, 0);
    a = 13'h053;
    fbegin(); send_instr(1'b1, 2'd0, a); rd_bytes(a, 1, "R11"); fend();

    // R9 pauses on byte boundaries, write then read
    w0 = we_cnt; a = 13'h060;
    fbegin(); send_instr(1'b0, 2'd2, a);
    wr_bytes(a, 1, 8'h4E); fend(); tick(20);
    fbegin(); wr_bytes(a, 1, 8'h7B); fend(); tick(20);
    fbegin(); wr_bytes(a, 1, 8'hE2); fend();
    drained("R9");
    chk(we_cnt - w0 == 3, "R9", "strobes across pauses", we_cnt - w0, 3);
    a = 13'h060;
    fbegin(); send_instr(1'b1, 2'd2, a);
    rd_bytes(a, 1, "R9"); fend(); tick(20);
    chk(!sdio_oe, "R9", "sdio released in pause", sdio_oe, 0);
    fbegin(); rd_bytes(a, 2, "R9"); fend();

    // R10 abort mid-byte and mid-header
    w0 = we_cnt; a = 13'h070;
    fbegin(); send_instr(1'b0, 2'd2, a); wr_bytes(a, 1, 8'h77);
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    fend();
    drained("R10");
    chk(we_cnt - w0 == 1, "R10", "partial byte dropped", we_cnt - w0, 1);
    fbegin(); for (int i = 0; i < 7; i++) send_bit(1'b1); fend();
    a = 13'h070;
    fbegin(); send_instr(1'b1, 2'd1, a); rd_bytes(a, 2, "R10"); fend();

    // R12 csb tied low from reset, back-to-back frames
    csb = 1'b0; rst_n = 1'b0; tick(5); rst_n = 1'b1; tick(6);
    send_instr(1'b0, 2'd0, 13'h080); send_byte(13'h080, 8'h3C);
    send_instr(1'b1, 2'd0, 13'h080);
    a = 13'h080; rd_bytes(a, 1, "R12");
    tick(6);
    chk(!sdio_oe, "R12", "frame closed by count", sdio_oe, 0);
    send_instr(1'b0, 2'd1, 13'h081); a = 13'h081; wr_bytes(a, 2, 8'h66);
    drained("R12");
    send_instr(1'b1, 2'd1, 13'h081); a = 13'h081; rd_bytes(a, 2, "R12");
    csb = 1'b1; tick(10);

    drained("R3");
    summary();
    $finish;
  end
endmodule